// File: doc/BRIEF.md
# Flash Bus Front-End with Reset Sequencing

This block sits between the external pins of a NOR-style flash memory model and its internal command unit. On every cycle it classifies the active-low control pins (reset, chip enable, output enable, write enable) into one of six bus modes. It drives the 16-bit data bus only when a read is legal. It turns each completed write pulse into a single strobe that carries the write's address and data.

It also owns reset behaviour. While the reset pin is low, the data bus is released and internal state is held at its defaults. If the command unit reports a busy erase or program when reset falls, the block raises a one-cycle abort flag with the address that is now corrupt. After reset is released, two separate wake-up counters gate read output and write acceptance. The read selection, the status byte and the read-configuration word come back at fixed defaults. A programming-voltage-valid input gates the commit permission that the command unit uses before it alters the array.

The write strobe is a stream with no back-pressure. `wr_valid` is high for exactly one cycle per accepted write, and the command unit must take it in that cycle, because a later write can replace it.

Top module: `flash_bus_frontend`

## Requirements
- R1: While `rst_pin_n` is low, `bus_mode` is 0, `dq_oe` is 0, `commit_en` is 0 and no `wr_valid` is produced, whatever the other pins do.
- R2: If `op_busy` was high at the last clock edge before `rst_pin_n` falls, `abort_pulse` is high for exactly one cycle after the first edge in reset, and `abort_addr` holds the `op_addr` sampled with it. If `op_busy` was low, no pulse is produced.
- R3: After `rst_pin_n` rises, `dq_oe` stays low until RD_WAKE rising clock edges have passed.
- R4: A write is dropped if its last sampled write-mode edge comes before WR_WAKE rising edges have passed since reset release.
- R5: After reset, the read selection is read-array, the status byte is 0x80, and the configuration word is 0x8000 (bit 15 set = asynchronous page-mode reads).
- R6: `bus_mode` encoding with reset high: chip enable high gives 1 (standby). Otherwise: oe_n=1 and we_n=1 gives 2 (output off), oe_n=0 and we_n=1 gives 3 (read), oe_n=1 and we_n=0 gives 4 (write), and both low gives 5 (contention). Contention neither drives the bus nor writes.
- R7: `dq_oe` is high only in mode 3 after the read wake-up. `dq_out` then carries `array_rdata` for selection 0 or 3, {0x00, status} for selection 1, and the configuration word for selection 2.
- R8: One rising edge after the first edge at which the pins have left write mode (the write enable or the chip enable rising ends the write), `wr_valid` is high for one cycle. It carries the address and data sampled at the last edge in write mode, and it stays low while the write is still active.
- R9: `commit_en` equals `commit_req` when `vpp_ok` is high and reset is high. It is 0 when `vpp_ok` is low.
- R10: `rsel_we`, `sr_we` and `rcr_we` update the read selection, status byte and configuration word at the next rising edge. Without them the values hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_pin_n | input | 1 | Active-low reset pin, asynchronous |
| chip_en_n | input | 1 | Active-low chip enable |
| out_en_n | input | 1 | Active-low output enable |
| wr_en_n | input | 1 | Active-low write enable |
| addr | input | ADDR_W | Bus address |
| dq_in | input | DATA_W | Data bus input side |
| dq_out | output | DATA_W | Data bus output side |
| dq_oe | output | 1 | Data bus drive enable (0 = high impedance) |
| bus_mode | output | 3 | Decoded bus mode (R6 encoding) |
| array_rdata | input | DATA_W | Array word for read-array mode |
| rsel_we | input | 1 | Load read selection |
| rsel_wdata | input | 2 | New read selection |
| sr_we | input | 1 | Load status byte |
| sr_wdata | input | SR_W | New status byte |
| rcr_we | input | 1 | Load configuration word |
| rcr_wdata | input | DATA_W | New configuration word |
| wr_valid | output | 1 | One-cycle write strobe |
| wr_addr | output | ADDR_W | Address of the strobed write |
| wr_data | output | DATA_W | Data of the strobed write |
| op_busy | input | 1 | Erase or program in progress |
| op_addr | input | ADDR_W | Target of the running operation |
| abort_pulse | output | 1 | Operation cut off by reset |
| abort_addr | output | ADDR_W | Location made invalid |
| commit_req | input | 1 | Command unit asks to alter the array |
| vpp_ok | input | 1 | Programming voltage valid |
| commit_en | output | 1 | Array alteration permitted |

## Verification
The bench drives pins on the falling clock edge and samples one time unit later. Mode, `dq_oe`, `dq_out` and `commit_en` are combinational from the pins, so they are checked in the same half cycle. Register loads and the abort flag are checked at the falling edge after the next rising edge. The write strobe is checked one full cycle after the pins leave write mode. For the wake-up windows, the bench counts rising edges since release: a read is expected to be driven at the sample taken after k edges exactly when k is at least RD_WAKE. A write whose low phase is sampled at edge off+1 is expected to strobe exactly when off is at least WR_WAKE, and both offsets are swept across each boundary.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;
  typedef enum logic [2:0] {
    BM_RESET   = 3'd0,
    BM_STANDBY = 3'd1,
    BM_OUT_OFF = 3'd2,
    BM_READ    = 3'd3,
    BM_WRITE   = 3'd4,
    BM_CONTEND = 3'd5
  } bus_mode_e;

  typedef enum logic [1:0] {
    RS_ARRAY  = 2'd0,
    RS_STATUS = 2'd1,
    RS_CONFIG = 2'd2,
    RS_ALT    = 2'd3
  } read_sel_e;
endpackage

// File: rtl/fe_bus_decode.sv
module fe_bus_decode
  import flash_fe_pkg::*;
(
  input  logic      rst_n,
  input  logic      ce_n,
  input  logic      oe_n,
  input  logic      we_n,
  output bus_mode_e mode
);
  always_comb begin
    if (!rst_n)                mode = BM_RESET;
    else if (ce_n)             mode = BM_STANDBY;
    else if (oe_n && we_n)     mode = BM_OUT_OFF;
    else if (!oe_n && we_n)    mode = BM_READ;
    else if (oe_n && !we_n)    mode = BM_WRITE;
    else                       mode = BM_CONTEND;
  end
endmodule

// File: rtl/fe_wake_timer.sv
module fe_wake_timer #(
  parameter int RD_WAKE = 4,
  parameter int WR_WAKE = 6
) (
  input  logic clk,
  input  logic rst_n,
  output logic rd_ok,
  output logic wr_ok
);
  localparam int SAT = (RD_WAKE > WR_WAKE) ? RD_WAKE : WR_WAKE;
  localparam int CW  = $clog2(SAT + 2);
  localparam logic [CW-1:0] SAT_C = CW'(SAT);
  localparam logic [CW-1:0] RD_C  = CW'(RD_WAKE);
  localparam logic [CW-1:0] WR_C  = CW'(WR_WAKE);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (cnt != SAT_C) cnt <= cnt + 1'b1;
  end

  assign rd_ok = (cnt >= RD_C);
  assign wr_ok = (cnt >= WR_C);

  assert_rd_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_ok) |-> ($past(cnt) == CW'(RD_WAKE - 1)));
  assert_wr_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_ok) |-> ($past(cnt) == CW'(WR_WAKE - 1)));
endmodule

// File: rtl/fe_write_capture.sv
module fe_write_capture #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_write,
  input  logic              wr_ok,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic              act;
  logic              act_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  assign act = in_write && wr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      act_q    <= act;
      if (act) begin
        addr_q <= addr;
        data_q <= din;
      end
      wr_valid <= act_q && !act;
      if (act_q && !act) begin
        wr_addr <= addr_q;
        wr_data <= data_q;
      end
    end
  end

  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
  assert_strobe_after_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(wr_ok, 2));
endmodule

// File: rtl/fe_reg_bank.sv
module fe_reg_bank
  import flash_fe_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SR_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rsel_we,
  input  logic [1:0]        rsel_wdata,
  input  logic              sr_we,
  input  logic [SR_W-1:0]   sr_wdata,
  input  logic              rcr_we,
  input  logic [DATA_W-1:0] rcr_wdata,
  input  logic [DATA_W-1:0] array_rdata,
  output logic [DATA_W-1:0] rd_word
);
  localparam logic [SR_W-1:0]   SR_DEF  = {1'b1, {(SR_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] RCR_DEF = {1'b1, {(DATA_W-1){1'b0}}};

  read_sel_e         sel;
  logic [SR_W-1:0]   sr;
  logic [DATA_W-1:0] rcr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel <= RS_ARRAY;
      sr  <= SR_DEF;
      rcr <= RCR_DEF;
    end else begin
      if (rsel_we) sel <= read_sel_e'(rsel_wdata);
      if (sr_we)   sr  <= sr_wdata;
      if (rcr_we)  rcr <= rcr_wdata;
    end
  end

  always_comb begin
    case (sel)
      RS_STATUS: rd_word = {{(DATA_W-SR_W){1'b0}}, sr};
      RS_CONFIG: rd_word = rcr;
      default:   rd_word = array_rdata;
    endcase
  end

  assert_sel_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rsel_we |=> $stable(sel));
  assert_status_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_we |=> $stable(sr));
endmodule

// File: rtl/flash_bus_frontend.sv
module flash_bus_frontend
  import flash_fe_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int SR_W    = 8,
  parameter int RD_WAKE = 4,
  parameter int WR_WAKE = 6
) (
  input  logic              clk,
  input  logic              rst_pin_n,
  input  logic              chip_en_n,
  input  logic              out_en_n,
  input  logic              wr_en_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic [2:0]        bus_mode,
  input  logic [DATA_W-1:0] array_rdata,
  input  logic              rsel_we,
  input  logic [1:0]        rsel_wdata,
  input  logic              sr_we,
  input  logic [SR_W-1:0]   sr_wdata,
  input  logic              rcr_we,
  input  logic [DATA_W-1:0] rcr_wdata,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              op_busy,
  input  logic [ADDR_W-1:0] op_addr,
  output logic              abort_pulse,
  output logic [ADDR_W-1:0] abort_addr,
  input  logic              commit_req,
  input  logic              vpp_ok,
  output logic              commit_en
);
  bus_mode_e mode;
  logic      rd_ok;
  logic      wr_ok;
  logic      armed;
  logic      busy_q;
  logic [ADDR_W-1:0] busy_addr_q;

  fe_bus_decode u_decode (
    .rst_n (rst_pin_n),
    .ce_n  (chip_en_n),
    .oe_n  (out_en_n),
    .we_n  (wr_en_n),
    .mode  (mode)
  );

  fe_wake_timer #(.RD_WAKE(RD_WAKE), .WR_WAKE(WR_WAKE)) u_wake (
    .clk   (clk),
    .rst_n (rst_pin_n),
    .rd_ok (rd_ok),
    .wr_ok (wr_ok)
  );

  fe_write_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wcap (
    .clk      (clk),
    .rst_n    (rst_pin_n),
    .in_write (mode == BM_WRITE),
    .wr_ok    (wr_ok),
    .addr     (addr),
    .din      (dq_in),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  fe_reg_bank #(.DATA_W(DATA_W), .SR_W(SR_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_pin_n),
    .rsel_we     (rsel_we),
    .rsel_wdata  (rsel_wdata),
    .sr_we       (sr_we),
    .sr_wdata    (sr_wdata),
    .rcr_we      (rcr_we),
    .rcr_wdata   (rcr_wdata),
    .array_rdata (array_rdata),
    .rd_word     (dq_out)
  );

  assign bus_mode  = mode;
  assign dq_oe     = rd_ok && (mode == BM_READ);
  assign commit_en = commit_req && vpp_ok && rst_pin_n;

  // armed is cleared the moment reset falls; busy_q still remembers the
  // last pre-reset edge, so their combination marks the first edge in reset.
  always_ff @(posedge clk or negedge rst_pin_n) begin
    if (!rst_pin_n) armed <= 1'b0;
    else            armed <= 1'b1;
  end

  always_ff @(posedge clk) begin
    busy_q      <= op_busy && armed;
    busy_addr_q <= op_addr;
    abort_pulse <= busy_q && !armed;
    if (busy_q && !armed) abort_addr <= busy_addr_q;
  end

  always_comb begin
    if (!rst_pin_n) begin
      assert_reset_quiet_R1: assert (!dq_oe && !commit_en);
    end
  end

  assert_abort_single_R2: assert property (@(posedge clk) disable iff (rst_pin_n)
    abort_pulse |=> !abort_pulse);
  assert_drive_only_read_R7: assert property (@(posedge clk) disable iff (!rst_pin_n)
    dq_oe |-> (bus_mode == 3'd3));
  assert_strobe_follows_write_R8: assert property (@(posedge clk) disable iff (!rst_pin_n)
    wr_valid |-> ($past(bus_mode, 2) == 3'd4));
endmodule

// File: tb/flash_bus_frontend_tb_top.sv
module flash_bus_frontend_tb_top;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int SW = 8;
  localparam int RDW = 3;
  localparam int WRW = 5;

  logic clk = 1'b0;
  logic rst_pin_n = 1'b0;
  logic chip_en_n = 1'b1, out_en_n = 1'b1, wr_en_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic dq_oe;
  logic [2:0] bus_mode;
  logic [DW-1:0] array_rdata = 16'hA5C3;
  logic rsel_we = 1'b0;
  logic [1:0] rsel_wdata = 2'd0;
  logic sr_we = 1'b0;
  logic [SW-1:0] sr_wdata = '0;
  logic rcr_we = 1'b0;
  logic [DW-1:0] rcr_wdata = '0;
  logic wr_valid;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic op_busy = 1'b0;
  logic [AW-1:0] op_addr = '0;
  logic abort_pulse;
  logic [AW-1:0] abort_addr;
  logic commit_req = 1'b0, vpp_ok = 1'b0;
  logic commit_en;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  flash_bus_frontend #(.ADDR_W(AW), .DATA_W(DW), .SR_W(SW),
                       .RD_WAKE(RDW), .WR_WAKE(WRW)) dut_i (
    .clk(clk), .rst_pin_n(rst_pin_n), .chip_en_n(chip_en_n),
    .out_en_n(out_en_n), .wr_en_n(wr_en_n), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .bus_mode(bus_mode),
    .array_rdata(array_rdata), .rsel_we(rsel_we), .rsel_wdata(rsel_wdata),
    .sr_we(sr_we), .sr_wdata(sr_wdata), .rcr_we(rcr_we), .rcr_wdata(rcr_wdata),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .op_busy(op_busy), .op_addr(op_addr), .abort_pulse(abort_pulse),
    .abort_addr(abort_addr), .commit_req(commit_req), .vpp_ok(vpp_ok),
    .commit_en(commit_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pins(input logic ce, input logic oe, input logic we);
    chip_en_n = ce; out_en_n = oe; wr_en_n = we;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    tick(); rst_pin_n = 1'b0;
    tick(); tick();
    rst_pin_n = 1'b1;
  endtask

  task automatic load_sel(input logic [1:0] s);
    rsel_we = 1'b1; rsel_wdata = s;
    tick(); rsel_we = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    #1;
    // R1 reset state
    chk("R1 mode in reset", bus_mode, 0);
    chk("R1 oe in reset", dq_oe, 0);
    chk("R1 strobe in reset", wr_valid, 0);
    chk("R2 no abort at start", abort_pulse, 0);
    for (int c = 0; c < 8; c++) begin
      tick();
      pins(c[2], c[1], c[0]); addr = AW'(c); commit_req = 1'b1; vpp_ok = 1'b1;
      #1;
      chk("R1 mode sweep in reset", bus_mode, 0);
      chk("R1 oe sweep in reset", dq_oe, 0);
      chk("R1 commit in reset", commit_en, 0);
      tick(); #1;
      chk("R1 strobe sweep in reset", wr_valid, 0);
    end
    commit_req = 1'b0;

    // R3 read wake-up, R5/R7 default array read
    tick();
    pins(1'b0, 1'b0, 1'b1);
    rst_pin_n = 1'b1;
    for (int k = 0; k < RDW + 4; k++) begin
      #1;
      chk("R3 read wake", dq_oe, (k >= RDW) ? 1 : 0);
      if (k >= RDW) chk("R5 default array read", dq_out, 32'hA5C3);
      tick();
    end

    // R6 decode sweep with reset high
    for (int c = 0; c < 8; c++) begin
      logic [2:0] em;
      pins(c[2], c[1], c[0]);
      #1;
      if (c[2]) em = 3'd1;
      else if (c[1] && c[0]) em = 3'd2;
      else if (!c[1] && c[0]) em = 3'd3;
      else if (c[1] && !c[0]) em = 3'd4;
      else em = 3'd5;
      chk("R6 decode", bus_mode, em);
      chk("R7 drive only in read", dq_oe, (em == 3'd3) ? 1 : 0);
      tick();
    end
    pins(1'b1, 1'b1, 1'b1);
    repeat (3) tick();

    // R8 write ended by write enable, last sample wins
    pins(1'b0, 1'b1, 1'b0); addr = 8'h11; dq_in = 16'h1111;
    tick(); #1;
    chk("R8 no strobe while writing", wr_valid, 0);
    addr = 8'h22; dq_in = 16'h2222;
    tick(); #1;
    chk("R8 no strobe while writing 2", wr_valid, 0);
    pins(1'b0, 1'b1, 1'b1);
    tick(); #1;
    chk("R8 strobe valid", wr_valid, 1);
    chk("R8 strobe addr", wr_addr, 32'h22);
    chk("R8 strobe data", wr_data, 32'h2222);
    tick(); #1;
    chk("R8 strobe one cycle", wr_valid, 0);

    // R8 write ended by chip enable
    pins(1'b0, 1'b1, 1'b0); addr = 8'h33; dq_in = 16'hBEEF;
    tick();
    pins(1'b1, 1'b1, 1'b0);
    tick(); #1;
    chk("R8 ce-ended strobe", wr_valid, 1);
    chk("R8 ce-ended data", wr_data, 32'hBEEF);
    pins(1'b1, 1'b1, 1'b1);
    tick(); #1;
    chk("R8 ce-ended one cycle", wr_valid, 0);

    // R6 contention: no drive, no write
    pins(1'b0, 1'b0, 1'b0);
    tick(); tick(); #1;
    chk("R6 contention no drive", dq_oe, 0);
    pins(1'b1, 1'b1, 1'b1);
    tick(); #1;
    chk("R6 contention no strobe", wr_valid, 0);
    tick(); #1;
    chk("R6 contention no strobe later", wr_valid, 0);

    // R10/R7 register loads and read selection
    pins(1'b0, 1'b0, 1'b1);
    load_sel(2'd1); #1;
    chk("R7 status default 0x80", dq_out, 32'h0080);
    sr_we = 1'b1; sr_wdata = 8'h3C; tick(); sr_we = 1'b0; #1;
    chk("R10 status load", dq_out, 32'h003C);
    sr_wdata = 8'hFF; tick(); #1;
    chk("R10 status holds", dq_out, 32'h003C);
    load_sel(2'd2); #1;
    chk("R7 config default", dq_out, 32'h8000);
    rcr_we = 1'b1; rcr_wdata = 16'h1234; tick(); rcr_we = 1'b0; #1;
    chk("R10 config load", dq_out, 32'h1234);
    load_sel(2'd3); #1;
    chk("R7 alt selection reads array", dq_out, 32'hA5C3);
    load_sel(2'd1);

    // R5 defaults after reset
    do_reset();
    repeat (RDW) tick();
    #1;
    chk("R5 read-array after reset", dq_out, 32'hA5C3);
    chk("R5 drive after wake", dq_oe, 1);
    load_sel(2'd1); #1;
    chk("R5 status default", dq_out, 32'h0080);
    load_sel(2'd2); #1;
    chk("R5 config default", dq_out, 32'h8000);
    pins(1'b1, 1'b1, 1'b1);
    tick(); tick();

    // R2 abort during busy operation
    op_busy = 1'b1; op_addr = 8'h5A;
    tick();
    rst_pin_n = 1'b0;
    tick(); #1;
    chk("R2 abort pulse", abort_pulse, 1);
    chk("R2 abort addr", abort_addr, 32'h5A);
    op_busy = 1'b0;
    tick(); #1;
    chk("R2 abort one cycle", abort_pulse, 0);
    rst_pin_n = 1'b1;
    repeat (3) tick();
    rst_pin_n = 1'b0;
    tick(); #1;
    chk("R2 no abort when idle", abort_pulse, 0);
    tick(); #1;
    chk("R2 no abort when idle later", abort_pulse, 0);
    rst_pin_n = 1'b1;

    // R4 write wake sweep
    for (int off = 0; off <= WRW + 2; off++) begin
      do_reset();
      repeat (off) tick();
      pins(1'b0, 1'b1, 1'b0); addr = AW'(off); dq_in = DW'(16'h4000 + off);
      tick();
      pins(1'b1, 1'b1, 1'b1);
      tick(); #1;
      chk("R4 write wake", wr_valid, (off >= WRW) ? 1 : 0);
      if (off >= WRW) chk("R4 accepted data", wr_data, 32'h4000 + off);
    end

    // R9 commit gating
    for (int c = 0; c < 4; c++) begin
      tick();
      commit_req = c[0]; vpp_ok = c[1];
      #1;
      chk("R9 commit gate", commit_en, (c == 3) ? 1 : 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule